// File: doc/BRIEF.md
# SMBus Host Notify Status and Interrupt Register Block

This block sits beside the slave engine of a two-wire management bus controller. It owns the two slave-side registers: a status register and a command register. When the bus logic reports that a Host Notify message arrived complete and valid, the block sets a pending flag. It also latches the sender's address and the 16-bit payload. While the flag is pending, it tells the bus logic to refuse the address byte of any further Host Notify transfer. The latched values therefore stay intact until software has read them and cleared the flag.

The pending flag is combined with the command-register enables. The result is a level interrupt request, which an external select input steers either to a normal interrupt line or to a system management interrupt line. The flag also feeds a wake output that merges it with the other bus wake sources. An external alert status feeds the same interrupt request, and a disable bit can mask it. That mask does not touch the wake output. Software reaches both registers through a simple port: byte address, write strobe, write data and combinational read data.

Top module: `smb_notify_regs`

## Requirements
- R1: After reset, the status register (offset 0x10) and the command register (offset 0x11) both read 0x00. Every unmapped offset reads 0x00. Bits 7:1 of the status register always read 0.
- R2: A one-cycle pulse on `nfy_done_i` sets the pending flag (status bit 0) at the next clock edge. When the flag was 0 before that edge, the same edge captures `nfy_addr_i` and `nfy_data_i` into `nfy_addr_o` and `nfy_data_o`.
- R3: Writing a byte with bit 0 = 1 to offset 0x10 clears the pending flag at the next edge. Writing bit 0 = 0 leaves the flag unchanged.
- R4: `nfy_nack_o` is high exactly while the pending flag is 1. While it is high, further `nfy_done_i` pulses leave `nfy_addr_o` and `nfy_data_o` unchanged.
- R5: When `nfy_done_i` and a clearing write arrive in the same cycle, the flag ends up set. New address and data are captured only if the flag was 0 before that cycle.
- R6: In the command register, bit 0 is the interrupt enable, bit 1 is the wake enable and bit 2 is the alert disable. A write takes effect at the next edge. Bits 7:3 read as 0.
- R7: The notify interrupt request equals the pending flag AND the interrupt enable, as a level. Enabling while the flag is set raises the request in the cycle after the write. Writing the enable never changes the flag.
- R8: With `route_smi_i` = 0 the combined request drives `irq_o` and `smi_o` stays 0. With `route_smi_i` = 1 the request drives `smi_o` and `irq_o` stays 0.
- R9: `wake_o` equals `other_wake_i` OR (pending flag AND wake enable).
- R10: The alert request equals `alert_sts_i` AND NOT alert disable, and it is ORed into the combined request. Alert input and alert disable have no effect on `wake_o`.
- R11: Asserting `rst_n` low clears the flag, the enables and the latched address and data at once. Release of the reset is synchronised through two flip-flops, so register updates resume on the third clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for `reg_addr_i` |
| nfy_done_i | input | 1 | Host Notify message received completely |
| nfy_addr_i | input | 7 | Address of the notifying device |
| nfy_data_i | input | 16 | Notify payload |
| nfy_nack_o | output | 1 | Refuse the address byte of new Host Notify transfers |
| nfy_addr_o | output | 7 | Latched notify address |
| nfy_data_o | output | 16 | Latched notify payload |
| route_smi_i | input | 1 | 1 selects the system management interrupt output |
| alert_sts_i | input | 1 | Alert status from the bus side |
| other_wake_i | input | 1 | OR of the other bus wake sources |
| irq_o | output | 1 | Normal interrupt request |
| smi_o | output | 1 | System management interrupt request |
| wake_o | output | 1 | Combined bus wake status |

## Verification
Register writes, notify pulses and reset-clear effects reach the flag, enables and latched values one clock edge after the cycle that carries them. Read data, NACK, interrupt, SMI and wake are combinational from that state and from the current inputs, so they follow in the same cycle. The bench drives stimulus on the falling edge. A behavioural model updates on each rising edge, and every output is compared 3 ns after that edge, once both the register and the combinational paths have settled. Directed checks read back the registers and outputs on the falling edge, one cycle after each stimulus. After reset release, the model holds its state for two edges to match the synchroniser.

// File: rtl/smb_notify_pkg.sv
package smb_notify_pkg;

  typedef struct packed {
    logic alert_dis;
    logic wake_en;
    logic int_en;
  } nfy_cmd_t;

  localparam int CMD_W = 3;

endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/smb_nfy_status.sv
module smb_nfy_status #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic              sts_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic              sts_q, sts_d;
  logic              cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // set has priority over software clear
  always_comb begin
    sts_d = sts_q;
    if (clr_i)  sts_d = 1'b0;
    if (done_i) sts_d = 1'b1;
  end

  // capture only into a free slot
  assign cap_en = done_i & ~sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign sts_o  = sts_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

endmodule

// File: rtl/smb_nfy_cmd.sv
module smb_nfy_cmd
  import smb_notify_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CMD_W-1:0] wdata_i,
  output nfy_cmd_t         cmd_o
);

  nfy_cmd_t cmd_q, cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (wr_i) cmd_d = nfy_cmd_t'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  assign cmd_o = cmd_q;

endmodule

// File: rtl/smb_nfy_irq.sv
module smb_nfy_irq
  import smb_notify_pkg::*;
(
  input  logic     sts_i,
  input  nfy_cmd_t cmd_i,
  input  logic     alert_sts_i,
  input  logic     other_wake_i,
  input  logic     route_smi_i,
  output logic     irq_o,
  output logic     smi_o,
  output logic     wake_o
);

  logic nfy_req;
  logic alert_req;
  logic any_req;

  assign nfy_req   = sts_i & cmd_i.int_en;
  assign alert_req = alert_sts_i & ~cmd_i.alert_dis;
  assign any_req   = nfy_req | alert_req;

  assign irq_o  = any_req & ~route_smi_i;
  assign smi_o  = any_req &  route_smi_i;
  assign wake_o = other_wake_i | (sts_i & cmd_i.wake_en);

endmodule

// File: rtl/smb_notify_regs.sv
module smb_notify_regs
  import smb_notify_pkg::*;
#(
  parameter int         REG_AW     = 8,
  parameter int         NFY_ADDR_W = 7,
  parameter int         NFY_DATA_W = 16,
  parameter int         RST_STAGES = 2,
  parameter logic [7:0] STS_OFS    = 8'h10,
  parameter logic [7:0] CMD_OFS    = 8'h11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_AW-1:0]     reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  input  logic                  nfy_done_i,
  input  logic [NFY_ADDR_W-1:0] nfy_addr_i,
  input  logic [NFY_DATA_W-1:0] nfy_data_i,
  output logic                  nfy_nack_o,
  output logic [NFY_ADDR_W-1:0] nfy_addr_o,
  output logic [NFY_DATA_W-1:0] nfy_data_o,
  input  logic                  route_smi_i,
  input  logic                  alert_sts_i,
  input  logic                  other_wake_i,
  output logic                  irq_o,
  output logic                  smi_o,
  output logic                  wake_o
);

  localparam int RSV_STS_W = 8 - 1;
  localparam int RSV_CMD_W = 8 - CMD_W;

  logic     rst_sync_n;
  logic     sel_sts, sel_cmd;
  logic     sts_clr, cmd_wr;
  logic     sts;
  nfy_cmd_t cmd;
  logic     unused_wdata;

  smb_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign sel_sts = (reg_addr_i == REG_AW'(STS_OFS));
  assign sel_cmd = (reg_addr_i == REG_AW'(CMD_OFS));
  assign sts_clr = reg_wr_i & sel_sts & reg_wdata_i[0];
  assign cmd_wr  = reg_wr_i & sel_cmd;
  assign unused_wdata = ^reg_wdata_i[7:CMD_W];

  smb_nfy_status #(.ADDR_W(NFY_ADDR_W), .DATA_W(NFY_DATA_W)) u_status (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .done_i (nfy_done_i),
    .addr_i (nfy_addr_i),
    .data_i (nfy_data_i),
    .clr_i  (sts_clr),
    .sts_o  (sts),
    .addr_o (nfy_addr_o),
    .data_o (nfy_data_o)
  );

  smb_nfy_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (cmd_wr),
    .wdata_i (reg_wdata_i[CMD_W-1:0]),
    .cmd_o   (cmd)
  );

  smb_nfy_irq u_irq (
    .sts_i        (sts),
    .cmd_i        (cmd),
    .alert_sts_i  (alert_sts_i),
    .other_wake_i (other_wake_i),
    .route_smi_i  (route_smi_i),
    .irq_o        (irq_o),
    .smi_o        (smi_o),
    .wake_o       (wake_o)
  );

  always_comb begin
    reg_rdata_o = 8'h00;
    if (sel_sts) reg_rdata_o = {{RSV_STS_W{1'b0}}, sts};
    if (sel_cmd) reg_rdata_o = {{RSV_CMD_W{1'b0}}, cmd};
  end

  assign nfy_nack_o = sts;

endmodule

// File: rtl/smb_notify_chk.sv
module smb_notify_chk #(
  parameter int         REG_AW = 8,
  parameter int         AW     = 7,
  parameter int         DW     = 16,
  parameter logic [7:0] STS_OFS = 8'h10
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic              nfy_done_i,
  input logic              nfy_nack_o,
  input logic [AW-1:0]     nfy_addr_o,
  input logic [DW-1:0]     nfy_data_o,
  input logic              irq_o,
  input logic              smi_o,
  input logic              wake_o,
  input logic              other_wake_i
);

  logic sts_wr1;
  assign sts_wr1 = reg_wr_i && (reg_addr_i == REG_AW'(STS_OFS)) && reg_wdata_i[0];

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr_i == REG_AW'(STS_OFS)) |-> (reg_rdata_o[7:1] == 7'd0)); // R1

  AST_NFY_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nfy_done_i |=> nfy_nack_o); // R2

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!nfy_done_i && sts_wr1) |=> !nfy_nack_o); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nfy_nack_o |=> ($stable(nfy_addr_o) && $stable(nfy_data_o))); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (nfy_done_i && sts_wr1) |=> nfy_nack_o); // R5

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(irq_o && smi_o)); // R8

  AST_WAKE_SRC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!other_wake_i && !nfy_nack_o) |-> !wake_o); // R9

endmodule

bind smb_notify_regs smb_notify_chk #(
  .REG_AW(REG_AW), .AW(NFY_ADDR_W), .DW(NFY_DATA_W), .STS_OFS(STS_OFS)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .reg_addr_i   (reg_addr_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .nfy_done_i   (nfy_done_i),
  .nfy_nack_o   (nfy_nack_o),
  .nfy_addr_o   (nfy_addr_o),
  .nfy_data_o   (nfy_data_o),
  .irq_o        (irq_o),
  .smi_o        (smi_o),
  .wake_o       (wake_o),
  .other_wake_i (other_wake_i)
);

// File: tb/smb_notify_regs_tb.sv
module smb_notify_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        nfy_done;
  logic [6:0]  nfy_addr;
  logic [15:0] nfy_data;
  logic        nfy_nack;
  logic [6:0]  lat_addr;
  logic [15:0] lat_data;
  logic        route_smi, alert_sts, other_wake;
  logic        irq, smi, wake;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  smb_notify_regs u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .nfy_done_i(nfy_done), .nfy_addr_i(nfy_addr), .nfy_data_i(nfy_data),
    .nfy_nack_o(nfy_nack), .nfy_addr_o(lat_addr), .nfy_data_o(lat_data),
    .route_smi_i(route_smi), .alert_sts_i(alert_sts), .other_wake_i(other_wake),
    .irq_o(irq), .smi_o(smi), .wake_o(wake)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        m_sts;
  logic [2:0]  m_cmd;
  logic [6:0]  m_a;
  logic [15:0] m_d;
  int          m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_cmd = 0; m_a = 0; m_d = 0; m_hold = 0;
    end else if (m_hold < 2) begin
      m_hold = m_hold + 1;                       // R11 two-stage release
    end else begin
      if (nfy_done && !m_sts) begin m_a = nfy_addr; m_d = nfy_data; end
      if (nfy_done) m_sts = 1;
      else if (reg_wr && reg_addr == 8'h10 && reg_wdata[0]) m_sts = 0;
      if (reg_wr && reg_addr == 8'h11) m_cmd = reg_wdata[2:0];
    end
  end

  always @(posedge clk) begin
    logic req;
    logic [7:0] exp_rd;
    #3;
    req = (m_sts & m_cmd[0]) | (alert_sts & ~m_cmd[2]);
    case (reg_addr)
      8'h10:   exp_rd = {7'd0, m_sts};
      8'h11:   exp_rd = {5'd0, m_cmd};
      default: exp_rd = 8'h00;
    endcase
    check("R1/R6 model rdata", reg_rdata, exp_rd);
    check("R4 model nack", nfy_nack, m_sts);
    check("R2 model addr", lat_addr, m_a);
    check("R2 model data", lat_data, m_d);
    check("R8 model irq", irq, req & ~route_smi);
    check("R8 model smi", smi, req & route_smi);
    check("R9 model wake", wake, other_wake | (m_sts & m_cmd[1]));
  end

  // ---------------- stimulus tasks (called at negedge) ----------------
  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
    #1;
  endtask

  task automatic notify(input logic [6:0] a, input logic [15:0] d);
    nfy_addr = a; nfy_data = d; nfy_done = 1;
    @(negedge clk);
    nfy_done = 0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
    nfy_done = 0; nfy_addr = 0; nfy_data = 0;
    route_smi = 0; alert_sts = 0; other_wake = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset values
    rd(8'h10, v); check("R1 status reset", v, 8'h00);
    rd(8'h11, v); check("R1 command reset", v, 8'h00);
    rd(8'h55, v); check("R1 unmapped read", v, 8'h00);
    check("R1 nack reset", nfy_nack, 0);

    // R2 notify capture
    @(negedge clk);
    notify(7'h2A, 16'hBEEF);
    rd(8'h10, v); check("R2 status set", v, 8'h01);
    check("R2 addr latched", lat_addr, 7'h2A);
    check("R2 data latched", lat_data, 16'hBEEF);

    // R4 nack and no overwrite
    check("R4 nack high", nfy_nack, 1);
    @(negedge clk);
    notify(7'h11, 16'h1234);
    check("R4 addr kept", lat_addr, 7'h2A);
    check("R4 data kept", lat_data, 16'hBEEF);

    // R7 level enable while pending
    @(negedge clk);
    check("R7 irq before enable", irq, 0);
    reg_write(8'h11, 8'h01);
    check("R7 irq after enable", irq, 1);
    rd(8'h10, v); check("R7 status untouched", v, 8'h01);

    // R8 routing
    route_smi = 1; #1;
    check("R8 smi routed", smi, 1);
    check("R8 irq quiet", irq, 0);
    route_smi = 0; #1;

    // R3 write-1-to-clear
    @(negedge clk);
    reg_write(8'h10, 8'hFE);
    check("R3 write0 keeps", nfy_nack, 1);
    @(negedge clk);
    reg_write(8'h10, 8'h01);
    check("R3 write1 clears", nfy_nack, 0);
    check("R3 irq drops", irq, 0);

    // R5 simultaneous set and clear, flag was 0
    @(negedge clk);
    reg_addr = 8'h10; reg_wdata = 8'h01; reg_wr = 1;
    notify(7'h33, 16'h0F0F);
    reg_wr = 0; #1;
    check("R5 set wins", nfy_nack, 1);
    check("R5 captured", lat_addr, 7'h33);
    // flag already 1
    @(negedge clk);
    reg_addr = 8'h10; reg_wdata = 8'h01; reg_wr = 1;
    notify(7'h44, 16'hAAAA);
    reg_wr = 0; #1;
    check("R5 set wins again", nfy_nack, 1);
    check("R5 no capture", lat_data, 16'h0F0F);

    // R9 wake
    @(negedge clk);
    reg_write(8'h11, 8'h02);
    check("R9 wake from status", wake, 1);
    check("R7 irq disabled", irq, 0);
    @(negedge clk);
    reg_write(8'h10, 8'h01);
    check("R9 wake low", wake, 0);
    other_wake = 1; #1;
    check("R9 other wake", wake, 1);
    other_wake = 0; #1;

    // R10 alert masking
    alert_sts = 1; #1;
    check("R10 alert unmasked", irq, 1);
    check("R10 alert not wake", wake, 0);
    @(negedge clk);
    reg_write(8'h11, 8'h06);
    check("R10 alert masked", irq, 0);
    check("R10 mask no wake", wake, 0);
    alert_sts = 0; #1;

    // R6 reserved command bits
    @(negedge clk);
    reg_write(8'h11, 8'hFF);
    rd(8'h11, v); check("R6 command readback", v, 8'h07);

    // R11 asynchronous reset mid-run
    @(negedge clk);
    notify(7'h55, 16'h5555);
    #1; rst_n = 0; #1;
    check("R11 nack cleared", nfy_nack, 0);
    check("R11 addr cleared", lat_addr, 7'h00);
    check("R11 data cleared", lat_data, 16'h0000);
    rd(8'h11, v); check("R11 command cleared", v, 8'h00);
    @(negedge clk);
    rst_n = 1;
    notify(7'h66, 16'h6666);     // edge 1 after release: ignored
    check("R11 held in sync", nfy_nack, 0);
    repeat (2) @(negedge clk);
    notify(7'h66, 16'h6666);
    check("R11 resumes", lat_addr, 7'h66);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule